// File: doc/BRIEF.md
# Lane-Partitioned Integer Adder

This block is a 64-bit integer adder whose carry chain can be cut at lane boundaries. One addition then yields several independent narrow sums packed side by side. A two-bit mode input picks the lane layout:

- one 64-bit lane;
- four 16-bit lanes;
- eight 8-bit lanes.

Inside the adder the 64 bits are split into byte-wide segments. A decoded mask says, for each internal byte boundary, whether the carry out of the lower byte is dropped before it reaches the upper byte. In each mode the carries that leave the top of each lane are packed into a flag vector, with lane 0 at bit 0.

The unit is registered and produces one result per clock. Operands and mode are sampled at a rising clock edge. The packed result and the flags appear on the outputs after that same edge and hold until the next one. A packer upstream places narrow values in the lanes, and consumers read the lanes back out.

Top module: `lane_add_top`

## Requirements
- R1: While the synchronous active-low reset `rstN` is low at a rising edge, `sum` and `carryFlags` become zero after that edge.
- R2: The mode code is decoded as follows: `2'b00` gives one 64-bit lane, `2'b01` gives four 16-bit lanes, `2'b10` gives eight 8-bit lanes, and `2'b11` behaves exactly like `2'b10`.
- R3: Operands and mode sampled at one rising edge determine `sum` and `carryFlags` immediately after that edge, so a new result is available every cycle.
- R4: In 64-bit mode, `sum` equals `opA + opB` modulo 2^64, and `carryFlags[0]` is the carry out of bit 63.
- R5: In 16-bit mode, each lane k (bits 16k+15 down to 16k) of `sum` is the sum of the matching operand lanes modulo 2^16, and no carry passes from one lane into the next.
- R6: In 8-bit mode, each lane k (bits 8k+7 down to 8k) of `sum` is the sum of the matching operand bytes modulo 2^8, and no carry passes between bytes.
- R7: `carryFlags[k]` is the carry out of the top bit of lane k. Flag bits for lanes that do not exist in the current mode read zero: bits 7..1 in 64-bit mode and bits 7..4 in 16-bit mode.
- R8: Within a lane wider than a byte, carries still ripple across the internal byte boundaries. For example, in 16-bit mode 0x00FF + 0x0001 gives 0x0100 in that lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Lane layout code (see R2) |
| opA | input | 64 | First packed operand |
| opB | input | 64 | Second packed operand |
| sum | output | 64 | Registered packed lane sums |
| carryFlags | output | 8 | Registered per-lane carry-out flags, lane 0 at bit 0 |

## Verification
Two things happen in the same cycle: a byte boundary kills a carry, and the carry out of the lane below that boundary is reported as a flag. The bench provokes this with operands whose bytes all overflow, for example 0xFF + 0x01 in every byte, and repeats them in each mode. It then judges that the upper lane's sum ignores the killed carry while the flag bit for the lower lane is still set. The same operands in 16-bit and 64-bit mode must instead let the carry ripple through the boundaries that are not lane edges, and must leave the flags for lanes that do not exist at zero.

// File: rtl/lane_add_pkg.sv
package lane_add_pkg;

  // Datapath geometry: full width, segment (smallest lane) width, middle lane width
  localparam int DATA_W    = 64;
  localparam int SEG_W     = 8;
  localparam int MID_W     = 16;
  localparam int NUM_SEG   = DATA_W / SEG_W;
  localparam int MID_SEGS  = MID_W / SEG_W;
  localparam int MID_LANES = DATA_W / MID_W;

  typedef enum logic [1:0] {
    MODE_FULL    = 2'b00,
    MODE_MID     = 2'b01,
    MODE_SEG     = 2'b10,
    MODE_SEG_ALT = 2'b11
  } laneMode_e;

  typedef enum logic [1:0] {
    FLAGS_FULL = 2'b00,
    FLAGS_MID  = 2'b01,
    FLAGS_SEG  = 2'b10
  } flagSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_SEG-2:0] killMask;  // bit i: drop carry from segment i into segment i+1
    flagSel_e           flagSel;   // which flag packing applies
  } laneCtl_t;

endpackage

// File: rtl/lane_add_ctrl.sv
module lane_add_ctrl
  import lane_add_pkg::*;
(
  input  logic [1:0] mode,
  output laneCtl_t   laneCtl
);

  // Boundary i (between segment i and i+1) is a lane edge when the lane
  // size in segments divides i+1.
  function automatic logic [NUM_SEG-2:0] edgeMask(input int segsPerLane);
    logic [NUM_SEG-2:0] m;
    m = '0;
    for (int i = 0; i < NUM_SEG - 1; i++) begin
      m[i] = (((i + 1) % segsPerLane) == 0);
    end
    return m;
  endfunction

  localparam logic [NUM_SEG-2:0] KILL_FULL = edgeMask(NUM_SEG);
  localparam logic [NUM_SEG-2:0] KILL_MID  = edgeMask(MID_SEGS);
  localparam logic [NUM_SEG-2:0] KILL_SEG  = edgeMask(1);

  always_comb begin
    unique case (laneMode_e'(mode))
      MODE_FULL: begin
        laneCtl.killMask = KILL_FULL;
        laneCtl.flagSel  = FLAGS_FULL;
      end
      MODE_MID: begin
        laneCtl.killMask = KILL_MID;
        laneCtl.flagSel  = FLAGS_MID;
      end
      default: begin
        laneCtl.killMask = KILL_SEG;
        laneCtl.flagSel  = FLAGS_SEG;
      end
    endcase
  end

endmodule

// File: rtl/lane_add_datapath.sv
module lane_add_datapath
  import lane_add_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  laneCtl_t           laneCtl,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  output logic [DATA_W-1:0]  sum,
  output logic [NUM_SEG-1:0] carryFlags
);

  logic [NUM_SEG-1:0] segCarry;
  logic [NUM_SEG-1:0] segCarryIn;
  logic [DATA_W-1:0]  sumNext;

  // Segmented ripple: each byte adds with a carry-in gated by the kill mask
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    if (s == 0) begin : g_first
      assign segCarryIn[s] = 1'b0;
    end else begin : g_rest
      assign segCarryIn[s] = segCarry[s-1] & ~laneCtl.killMask[s-1];
    end
    assign {segCarry[s], sumNext[s*SEG_W +: SEG_W]} =
      {1'b0, opA[s*SEG_W +: SEG_W]} + {1'b0, opB[s*SEG_W +: SEG_W]}
      + {{SEG_W{1'b0}}, segCarryIn[s]};
  end

  // Flag packing for each lane layout
  logic [NUM_SEG-1:0] flagsFull;
  logic [NUM_SEG-1:0] flagsMid;
  logic [NUM_SEG-1:0] flagsSeg;
  logic [NUM_SEG-1:0] flagsNext;

  assign flagsFull = {{(NUM_SEG-1){1'b0}}, segCarry[NUM_SEG-1]};
  assign flagsSeg  = segCarry;

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_midFlag
    if (k < MID_LANES) begin : g_live
      assign flagsMid[k] = segCarry[(k+1)*MID_SEGS-1];
    end else begin : g_idle
      assign flagsMid[k] = 1'b0;
    end
  end

  always_comb begin
    unique case (laneCtl.flagSel)
      FLAGS_FULL: flagsNext = flagsFull;
      FLAGS_MID:  flagsNext = flagsMid;
      default:    flagsNext = flagsSeg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sum        <= '0;
      carryFlags <= '0;
    end else begin
      sum        <= sumNext;
      carryFlags <= flagsNext;
    end
  end

endmodule

// File: rtl/lane_add_top.sv
module lane_add_top
  import lane_add_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         mode,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  output logic [DATA_W-1:0]  sum,
  output logic [NUM_SEG-1:0] carryFlags
);

  laneCtl_t laneCtl;

  lane_add_ctrl i_ctrl (
    .mode    (mode),
    .laneCtl (laneCtl)
  );

  lane_add_datapath i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .laneCtl    (laneCtl),
    .opA        (opA),
    .opB        (opB),
    .sum        (sum),
    .carryFlags (carryFlags)
  );

endmodule

// File: rtl/lane_add_chk.sv
module lane_add_chk
  import lane_add_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [1:0]         mode,
  input logic [DATA_W-1:0]  opA,
  input logic [DATA_W-1:0]  opB,
  input logic [DATA_W-1:0]  sum,
  input logic [NUM_SEG-1:0] carryFlags
);

  // High once the output register has captured a real operand pair
  logic primed;
  always_ff @(posedge clk) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  function automatic logic [DATA_W-1:0] refSum(input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b,
                                               input int w);
    logic [DATA_W:0]   mask, la, lb, tot;
    logic [DATA_W-1:0] res;
    res  = '0;
    mask = (w >= DATA_W) ? {1'b0, {DATA_W{1'b1}}} : (((DATA_W+1)'(1)) << w) - 1;
    for (int k = 0; k < DATA_W / w; k++) begin
      la  = ({1'b0, a} >> (k*w)) & mask;
      lb  = ({1'b0, b} >> (k*w)) & mask;
      tot = la + lb;
      res = res | (DATA_W'(tot & mask) << (k*w));
    end
    return res;
  endfunction

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> (sum == '0 && carryFlags == '0)); // R1

  AST_FULL_SUM: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(mode) == MODE_FULL) |->
      ({carryFlags[0], sum} == {1'b0, $past(opA)} + {1'b0, $past(opB)})); // R4

  AST_MID_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(mode) == MODE_MID) |->
      (sum == refSum($past(opA), $past(opB), MID_W))); // R5

  AST_SEG_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(mode[1])) |->
      (sum == refSum($past(opA), $past(opB), SEG_W))); // R6

  AST_IDLE_FULL_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(mode) == MODE_FULL) |->
      (carryFlags[NUM_SEG-1:1] == '0)); // R7

  AST_IDLE_MID_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(mode) == MODE_MID) |->
      ((carryFlags >> MID_LANES) == '0)); // R7

endmodule

bind lane_add_top lane_add_chk u_chk (.*);

// File: tb/test_lane_add_top.sv
module test_lane_add_top;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [63:0] expSum;
    logic [7:0]  expFlags;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [63:0] sum;
  logic [7:0]  carryFlags;

  int checks = 0;
  int errors = 0;
  bit monitorOn = 1'b0;
  item_t q[$];
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  lane_add_top i_lane_add_top (
    .clk(clk), .rstN(rstN), .mode(mode), .opA(opA), .opB(opB),
    .sum(sum), .carryFlags(carryFlags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Independent model: lanes of width w, sums modulo 2^w, flag k = lane k carry
  function automatic item_t model(input logic [1:0] m, input logic [63:0] a,
                                  input logic [63:0] b, input string req);
    item_t it;
    int w;
    logic [64:0] tot;
    logic [63:0] mask;
    w = (m == 2'b00) ? 64 : (m == 2'b01) ? 16 : 8;
    mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    it.expSum = '0;
    it.expFlags = '0;
    it.req = req;
    for (int k = 0; k < 64 / w; k++) begin
      tot = {1'b0, (a >> (k*w)) & mask} + {1'b0, (b >> (k*w)) & mask};
      it.expSum = it.expSum | ((tot[63:0] & mask) << (k*w));
      it.expFlags[k] = (w == 64) ? tot[64] : tot[w];
    end
    return it;
  endfunction

  task automatic drive(input logic [1:0] m, input logic [63:0] a,
                       input logic [63:0] b, input string req);
    @(negedge clk);
    mode = m; opA = a; opB = b;
    q.push_back(model(m, a, b, req));
  endtask

  task automatic checkVal(input string req, input logic [63:0] act,
                          input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] nextRand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 7);
    lfsr = lfsr ^ (lfsr << 17);
    return lfsr;
  endfunction

  // Monitor: result of the item driven before an edge shows right after it (R3)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (monitorOn && q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checkVal({it.req, "/R3 sum"}, sum, it.expSum);
        checkVal({it.req, "/R7 flags"}, {56'd0, carryFlags}, {56'd0, it.expFlags});
      end
    end
  end

  initial begin
    fork
      begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none
  end

  initial begin
    opA = '1; opB = '1; mode = 2'b10;
    repeat (3) @(negedge clk);
    // R1: reset clears outputs despite nonzero operands
    checkVal("R1 sum", sum, 64'd0);
    checkVal("R1 flags", {56'd0, carryFlags}, 64'd0);
    monitorOn = 1'b1;
    @(negedge clk);
    rstN = 1'b1;

    // R4: full-width add with carry out of bit 63
    drive(2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R4");
    drive(2'b00, 64'h0123_4567_89AB_CDEF, 64'h1111_1111_1111_1111, "R4");
    drive(2'b00, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, "R4");
    // R6: every byte overflows, carries killed, all flags set
    drive(2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, "R6");
    drive(2'b10, 64'h807F_FF00_0180_7FFE, 64'h8081_0100_FF80_0102, "R6");
    // R2: code 11 behaves as byte lanes
    drive(2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, "R2");
    // R5: 16-bit lanes overflow independently
    drive(2'b01, 64'hFFFF_0001_8000_FFFF, 64'h0001_FFFF_8000_0001, "R5");
    // R8: carry ripples across byte boundary inside a 16-bit lane
    drive(2'b01, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, "R8");
    drive(2'b00, 64'h0000_0000_00FF_FFFF, 64'h0000_0000_0000_0001, "R8");
    // R7: same overflow pattern in each mode, idle flags stay zero
    drive(2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
    drive(2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R7");

    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      a = nextRand();
      b = nextRand();
      drive(2'(i % 4), a, b, (i % 4 == 0) ? "R4" : (i % 4 == 1) ? "R5" : "R6");
    end

    repeat (3) @(negedge clk);
    checkVal("R3 drained", 64'(q.size()), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule